// File: doc/BRIEF.md
# Serial EEPROM Slave Command Engine

This block is the digital side of a byte-wide serial memory that acts as an SPI slave. When chip select falls, the first byte on the data input is decoded as a command. The commands let a host set or clear a write-enable latch, read or write a status byte, stream data out from any address, and load up to one page of bytes for a write. After a write or a status write is accepted, an internal write cycle runs for a fixed number of system clocks. A busy flag is set while it runs. During that time the buffered page is copied into the storage array.

All serial pins are oversampled by the system clock. Each pin passes through a two-stage synchronizer, and clock and select edges are found by comparing the synchronized value with the previous one. A hold input can pause a transfer without losing its place. An unknown command, or a command that is not allowed in the current state, silences the slave until chip select is released and asserted again. The data output comes with a separate enable for an external tri-state driver.

The storage array is addressed with 16 bits. Only the low `MEM_AW` address bits select a physical byte, so a smaller array repeats across the address space. `WRITE_CYCLES` must be at least `PAGE_BYTES`, so that the copy from the page buffer finishes inside the busy window.

Top module: `ee_spi_slave`

## Requirements
- R1: Serial clock modes 0 and 3 both work. Input is sampled on a rising serial clock edge, the output changes on a falling edge, and every byte moves most significant bit first.
- R2: The first byte after chip select falls is the command. The command codes are 0x06 set write enable, 0x04 clear write enable, 0x05 read status, 0x01 write status, 0x03 read and 0x02 write. Read and write are followed by a 16-bit address, high byte first.
- R3: The status byte has bit 0 = busy, bit 1 = write enable, and bits 7:2 = a user field set by write status. The set and clear commands take effect when chip select rises on a whole byte boundary.
- R4: After an unknown command, no further input is taken and the output enable stays low until chip select rises and falls again. The next transfer then works normally.
- R5: While chip select is high, clock and data input have no effect and the output enable is low.
- R6: Hold begins or ends only while the serial clock is low. While hold is in effect, clock edges and data input are ignored, the output enable is low, and the transfer resumes exactly where it stopped.
- R7: A write stores bytes into a page buffer. The address wraps within its 128-byte page. The buffer is committed only if chip select rises after at least one whole byte; a partial last byte cancels the whole write and starts no busy cycle.
- R8: A read returns consecutive bytes. The address increments after each byte and wraps from 0xFFFF to 0x0000.
- R9: After a commit, busy reads 1 for `WRITE_CYCLES` clocks. During that time every command except read status is treated as unknown. When the cycle ends, the write-enable bit clears.
- R10: Write and write-status commands issued while write enable is clear are treated as unknown and change nothing.
- R11: After reset, the status byte is 0x00 and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause input, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Enable for the external tri-state driver of `so` |

## Verification
The assertions rely on every level of the serial clock, and every change of chip select or hold, lasting at least three system clocks. They also rely on chip select and hold changing only while the serial clock is steady. Under these conditions each edge is seen exactly once after synchronization. The stimulus holds each clock phase for eight system clocks. It changes data, select and hold only on falling system clock edges, and it starts or ends hold only while the serial clock is low. It also waits longer than the busy window before any command that must not be refused.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_WDATA, ST_RDATA, ST_RSTAT, ST_WSR, ST_DONE, ST_LOCK
  } ee_state_t;

  // sequential read: full 16-bit increment, wraps at the top
  function automatic logic [15:0] rd_next(input logic [15:0] a);
    return a + 16'd1;
  endfunction

  // page write: increment only the low pbits, keep the page number
  function automatic logic [15:0] pg_next(input logic [15:0] a, input int unsigned pbits);
    logic [15:0] m;
    m = 16'((32'd1 << pbits) - 32'd1);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction
endpackage

// File: rtl/ee_pin_sync.sv
module ee_pin_sync #(
  parameter int unsigned N = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
      end else begin
        s1 <= raw[g];
        s2 <= s1;
      end
    end
    assign q[g] = s2;
  end
endmodule

// File: rtl/ee_busy_timer.sv
module ee_busy_timer #(
  parameter int unsigned CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == CW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + CW'(1);
      if (done) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/ee_store.sv
module ee_store #(
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end
  assign rdata = mem[raddr];
endmodule

// File: rtl/ee_spi_slave.sv
module ee_spi_slave
  import ee_pkg::*;
#(
  parameter int unsigned MEM_AW       = 11,
  parameter int unsigned PAGE_BYTES   = 128,
  parameter int unsigned WRITE_CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic so,
  output logic so_oe
);
  localparam int unsigned PB = $clog2(PAGE_BYTES);

  // synchronized pins: {hold_n, si, sck, cs_n}
  logic [3:0] pins_q;
  ee_pin_sync #(.N(4), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({hold_n, si, sck, cs_n}), .q(pins_q)
  );
  logic cs_q, sck_q, si_q, hold_in;
  assign cs_q    = pins_q[0];
  assign sck_q   = pins_q[1];
  assign si_q    = pins_q[2];
  assign hold_in = pins_q[3];

  logic cs_d, sck_d, hold_act;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d     <= 1'b1;
      sck_d    <= 1'b0;
      hold_act <= 1'b0;
    end else begin
      cs_d  <= cs_q;
      sck_d <= sck_q;
      if (cs_q)        hold_act <= 1'b0;
      else if (!sck_q) hold_act <= !hold_in;
    end
  end

  // named events
  logic active, sck_rise_ev, sck_fall_ev, cs_rise_ev, byte_ev, opc_ev;
  assign active      = !cs_q && !hold_act;
  assign sck_rise_ev = active && sck_q && !sck_d;
  assign sck_fall_ev = active && !sck_q && sck_d;
  assign cs_rise_ev  = cs_q && !cs_d;

  ee_state_t  st;
  logic [7:0] op_q;
  logic [6:0] rx_sh;
  logic [2:0] bit_cnt;
  logic [7:0] rx_byte;
  logic [15:0] addr_q;
  logic        hi_done;
  logic        wel;
  logic [5:0]  sr_user, wsr_new;
  logic        wsr_have;
  logic [7:0]  tx_sh;
  logic [2:0]  tx_cnt;
  logic        tx_on, so_r;
  logic [PAGE_BYTES-1:0] pvalid;
  logic [15-PB:0] page_base;
  logic           commit_pend;
  logic [PB-1:0]  commit_idx;
  logic           busy, busy_done;

  assign rx_byte = {rx_sh, si_q};
  assign byte_ev = sck_rise_ev && (st != ST_LOCK) && (bit_cnt == 3'd7);
  assign opc_ev  = byte_ev && (st == ST_OPC);

  // commit decisions at chip-select release
  logic wren_commit, wrdi_commit, wsr_commit, page_commit, commit_start;
  assign wren_commit  = cs_rise_ev && st == ST_DONE && op_q == OP_WREN && bit_cnt == 3'd0;
  assign wrdi_commit  = cs_rise_ev && st == ST_DONE && op_q == OP_WRDI && bit_cnt == 3'd0;
  assign wsr_commit   = cs_rise_ev && st == ST_DONE && wsr_have && bit_cnt == 3'd0;
  assign page_commit  = cs_rise_ev && st == ST_WDATA && bit_cnt == 3'd0 && (|pvalid);
  assign commit_start = wsr_commit || page_commit;

  logic [7:0] status, mem_rdata, cur_byte;
  assign status   = {sr_user, wel, busy};
  assign cur_byte = (st == ST_RSTAT) ? status : mem_rdata;

  ee_busy_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(commit_start), .busy(busy), .done(busy_done)
  );

  // page buffer
  logic [7:0] pbuf [PAGE_BYTES];
  always_ff @(posedge clk) begin
    if (!cs_q && byte_ev && st == ST_WDATA) pbuf[addr_q[PB-1:0]] <= rx_byte;
  end

  logic          commit_we;
  logic [15:0]   commit_addr;
  assign commit_we   = commit_pend && pvalid[commit_idx];
  assign commit_addr = {page_base, commit_idx};

  ee_store #(.AW(MEM_AW)) u_store (
    .clk(clk), .we(commit_we), .waddr(commit_addr[MEM_AW-1:0]),
    .wdata(pbuf[commit_idx]), .raddr(addr_q[MEM_AW-1:0]), .rdata(mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_OPC; op_q <= '0; rx_sh <= '0; bit_cnt <= '0;
      addr_q <= '0; hi_done <= 1'b0; wel <= 1'b0;
      sr_user <= '0; wsr_new <= '0; wsr_have <= 1'b0;
      tx_sh <= '0; tx_cnt <= '0; tx_on <= 1'b0; so_r <= 1'b0;
      pvalid <= '0; page_base <= '0; commit_pend <= 1'b0; commit_idx <= '0;
    end else begin
      if (busy_done)   wel <= 1'b0;
      if (wren_commit) wel <= 1'b1;
      if (wrdi_commit) wel <= 1'b0;
      if (wsr_commit)  sr_user <= wsr_new;

      if (cs_q) begin
        st <= ST_OPC; bit_cnt <= '0; tx_cnt <= '0; tx_on <= 1'b0;
        wsr_have <= 1'b0; hi_done <= 1'b0;
      end else begin
        if (sck_rise_ev && st != ST_LOCK) begin
          rx_sh   <= rx_byte[6:0];
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (byte_ev) begin
          case (st)
            ST_OPC: begin
              op_q <= rx_byte;
              if (busy && rx_byte != OP_RDSR) st <= ST_LOCK;
              else begin
                case (rx_byte)
                  OP_RDSR:          st <= ST_RSTAT;
                  OP_READ:          st <= ST_ADDR;
                  OP_WRITE:         st <= wel ? ST_ADDR : ST_LOCK;
                  OP_WREN, OP_WRDI: st <= ST_DONE;
                  OP_WRSR:          st <= wel ? ST_WSR : ST_LOCK;
                  default:          st <= ST_LOCK;
                endcase
              end
            end
            ST_ADDR: begin
              if (!hi_done) begin
                addr_q[15:8] <= rx_byte;
                hi_done      <= 1'b1;
              end else begin
                addr_q[7:0] <= rx_byte;
                if (op_q == OP_WRITE) begin
                  st     <= ST_WDATA;
                  pvalid <= '0;
                end else st <= ST_RDATA;
              end
            end
            ST_WDATA: begin
              pvalid[addr_q[PB-1:0]] <= 1'b1;
              addr_q <= pg_next(addr_q, PB);
            end
            ST_WSR: begin
              wsr_new  <= rx_byte[7:2];
              wsr_have <= 1'b1;
              st       <= ST_DONE;
            end
            default: ;
          endcase
        end
        if (sck_fall_ev && (st == ST_RDATA || st == ST_RSTAT)) begin
          if (tx_cnt == 3'd0) begin
            so_r  <= cur_byte[7];
            tx_sh <= {cur_byte[6:0], 1'b0};
            tx_on <= 1'b1;
            if (st == ST_RDATA) addr_q <= rd_next(addr_q);
          end else begin
            so_r  <= tx_sh[7];
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
          tx_cnt <= tx_cnt + 3'd1;
        end
      end

      if (page_commit) begin
        commit_pend <= 1'b1;
        commit_idx  <= '0;
        page_base   <= addr_q[15:PB];
      end else if (commit_pend) begin
        commit_idx <= commit_idx + PB'(1);
        if (commit_idx == PB'(PAGE_BYTES - 1)) commit_pend <= 1'b0;
      end
    end
  end

  assign so    = so_r;
  assign so_oe = tx_on && !hold_act && !cs_q;
endmodule

// File: rtl/ee_spi_checker.sv
module ee_spi_checker #(
  parameter int unsigned PB = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_q,
  input logic         so_oe,
  input logic [2:0]   st,
  input logic         busy,
  input logic         busy_done,
  input logic         wel,
  input logic         opc_ev,
  input logic         byte_ev,
  input logic         hold_act,
  input logic [2:0]   bit_cnt,
  input logic [15-PB:0] page_bits,
  input logic         commit_we
);
  import ee_pkg::*;

  // R4: a locked interface never drives
  a_r4_lock_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'(ST_LOCK)) |-> !so_oe);

  // R9: while busy, a decoded command ends up locked or in status read
  a_r9_only_status_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_ev && busy) |=> (st == 3'(ST_LOCK) || st == 3'(ST_RSTAT)));

  // R9: end of the write cycle drops write enable
  a_r9_wel_clears: assert property (@(posedge clk) disable iff (!rst_n)
    busy_done |=> !wel);

  // R6: hold keeps the bit position
  a_r6_hold_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && !cs_q) |=> $stable(bit_cnt));

  // R7: page bytes never leave their page
  a_r7_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ev && st == 3'(ST_WDATA)) |=> $stable(page_bits));

  // R7: array writes happen only inside the busy window
  a_r7_commit_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit_we |-> busy);
endmodule

bind ee_spi_slave ee_spi_checker #(.PB(PB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .so_oe(so_oe), .st(st),
  .busy(busy), .busy_done(busy_done), .wel(wel), .opc_ev(opc_ev),
  .byte_ev(byte_ev), .hold_act(hold_act), .bit_cnt(bit_cnt),
  .page_bits(addr_q[15:PB]), .commit_we(commit_we)
);

// File: tb/tb_ee_spi_slave.sv
`timescale 1ns/1ps
module tb_ee_spi_slave;
  localparam int unsigned WC = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe;

  ee_spi_slave #(.MEM_AW(11), .PAGE_BYTES(128), .WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .so(so), .so_oe(so_oe)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  bit mode3 = 1'b0;

  // scoreboard
  logic [7:0] exp_q [$];
  string      tag_q [$];
  bit         mon_on = 1'b0;
  logic [7:0] cap = '0;
  int         ncap = 0;
  bit         oe_bad = 1'b0;
  bit         quiet_on = 1'b0, quiet_bad = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  always @(posedge sck) begin
    if (mon_on) begin
      cap = {cap[6:0], so};
      if (so_oe !== 1'b1) oe_bad = 1'b1;
      ncap++;
      if (ncap == 8) begin
        ncap = 0;
        if (exp_q.size() == 0) check(1'b0, "scoreboard underflow", cap, 8'h00);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(!oe_bad && cap === e, t, cap, e);
        end
        oe_bad = 1'b0;
      end
    end
  end

  always @(negedge clk) if (quiet_on && so_oe !== 1'b0) quiet_bad = 1'b1;

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_begin();
    sck = mode3;
    wait_clks(4);
    cs_n = 1'b0;
    wait_clks(8);
  endtask

  task automatic cs_end();
    wait_clks(8);
    cs_n = 1'b1;
    wait_clks(8);
  endtask

  task automatic send_bits(input logic [7:0] b, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) begin
      if (mode3) sck = 1'b0;
      si = b[i];
      wait_clks(8);
      sck = 1'b1;
      wait_clks(8);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 7, 0);
  endtask

  task automatic expect_byte(input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic cmd(input logic [7:0] op);
    cs_begin(); send_byte(op); cs_end();
  endtask

  task automatic rdsr_check(input logic [7:0] e, input string t);
    cs_begin();
    send_byte(8'h05);
    expect_byte(e, t);
    mon_on = 1'b1;
    send_byte(8'h00);
    mon_on = 1'b0;
    cs_end();
  endtask

  task automatic write_page(input logic [15:0] a, input logic [7:0] d [4], input int n);
    cmd(8'h06);
    cs_begin();
    send_byte(8'h02); send_byte(a[15:8]); send_byte(a[7:0]);
    for (int i = 0; i < n; i++) send_byte(d[i]);
    cs_end();
  endtask

  task automatic read_check(input logic [15:0] a, input logic [7:0] d [4], input int n, input string t);
    cs_begin();
    send_byte(8'h03); send_byte(a[15:8]); send_byte(a[7:0]);
    for (int i = 0; i < n; i++) expect_byte(d[i], t);
    mon_on = 1'b1;
    for (int i = 0; i < n; i++) send_byte(8'h00);
    mon_on = 1'b0;
    cs_end();
  endtask

  task automatic summary();
    if (exp_q.size() != 0) check(1'b0, "scoreboard leftover", 8'(exp_q.size()), 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", 8'h00, 8'h01);
      summary();
      $finish;
    end
  end

  initial begin
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(5);
    // R11 reset state
    check(so_oe === 1'b0, "R11 output enable after reset", {7'b0, so_oe}, 8'h00);
    rdsr_check(8'h00, "R11 status after reset");

    // R5: clocking a set-enable command with chip select high does nothing
    quiet_on = 1'b1; quiet_bad = 1'b0;
    send_byte(8'h06);
    quiet_on = 1'b0;
    check(!quiet_bad, "R5 output enable while deselected", {7'b0, quiet_bad}, 8'h00);
    rdsr_check(8'h00, "R5 input ignored while deselected");

    // R3 write enable latch
    cmd(8'h06);
    rdsr_check(8'h02, "R3 set write enable");
    cmd(8'h04);
    rdsr_check(8'h00, "R3 clear write enable");

    // R7/R9: page write in mode 0, then busy behaviour
    write_page(16'h0100, '{8'h11, 8'h22, 8'h33, 8'h00}, 3);
    rdsr_check(8'h03, "R9 busy and enable during write cycle");
    quiet_on = 1'b1; quiet_bad = 1'b0;
    cs_begin(); send_byte(8'h03); send_byte(8'h01); send_byte(8'h00); send_byte(8'h00); cs_end();
    quiet_on = 1'b0;
    check(!quiet_bad, "R9 read refused while busy", {7'b0, quiet_bad}, 8'h00);
    wait_clks(WC + 100);
    rdsr_check(8'h00, "R9 enable cleared after write cycle");

    // R1/R2/R8: read back in mode 3
    mode3 = 1'b1;
    read_check(16'h0100, '{8'h11, 8'h22, 8'h33, 8'h00}, 3, "R1 R2 mode 3 sequential read");
    mode3 = 1'b0;

    // R10: write without enable is ignored
    cs_begin(); send_byte(8'h02); send_byte(8'h01); send_byte(8'h00); send_byte(8'h99); cs_end();
    rdsr_check(8'h00, "R10 no busy after unenabled write");
    read_check(16'h0100, '{8'h11, 8'h00, 8'h00, 8'h00}, 1, "R10 array unchanged");

    // R7 page wrap
    write_page(16'h027E, '{8'hA0, 8'hA1, 8'hA2, 8'hA3}, 4);
    wait_clks(WC + 100);
    read_check(16'h0200, '{8'hA2, 8'hA3, 8'h00, 8'h00}, 2, "R7 wrapped bytes at page start");
    read_check(16'h027E, '{8'hA0, 8'hA1, 8'h00, 8'h00}, 2, "R7 bytes at page end");

    // R8 read wrap at top of address space
    write_page(16'hFFFF, '{8'h5C, 8'h00, 8'h00, 8'h00}, 1);
    wait_clks(WC + 100);
    write_page(16'h0000, '{8'hC5, 8'h00, 8'h00, 8'h00}, 1);
    wait_clks(WC + 100);
    read_check(16'hFFFF, '{8'h5C, 8'hC5, 8'h00, 8'h00}, 2, "R8 read wraps to zero");

    // R7 partial byte cancels the write
    cmd(8'h06);
    cs_begin(); send_byte(8'h02); send_byte(8'h01); send_byte(8'h01); send_bits(8'hEE, 7, 4); cs_end();
    rdsr_check(8'h02, "R7 partial byte starts no cycle");
    read_check(16'h0101, '{8'h22, 8'h00, 8'h00, 8'h00}, 1, "R7 partial byte leaves array");
    cmd(8'h04);

    // R4 unknown command locks the transfer
    quiet_on = 1'b1; quiet_bad = 1'b0;
    cs_begin(); send_byte(8'hFF); send_byte(8'h05); send_byte(8'h00); cs_end();
    quiet_on = 1'b0;
    check(!quiet_bad, "R4 output stays off after unknown command", {7'b0, quiet_bad}, 8'h00);
    rdsr_check(8'h00, "R4 next transfer works");

    // R6 hold in the middle of a read byte
    cs_begin();
    send_byte(8'h03); send_byte(8'h01); send_byte(8'h00);
    expect_byte(8'h11, "R6 byte across hold");
    expect_byte(8'h22, "R6 byte after hold");
    mon_on = 1'b1;
    send_bits(8'h00, 7, 4);
    mon_on = 1'b0;
    hold_n = 1'b0;
    wait_clks(8);
    check(so_oe === 1'b0, "R6 output off during hold", {7'b0, so_oe}, 8'h00);
    for (int k = 0; k < 3; k++) begin
      si = 1'b1; sck = 1'b1; wait_clks(8); sck = 1'b0; wait_clks(8);
    end
    hold_n = 1'b1;
    wait_clks(8);
    mon_on = 1'b1;
    send_bits(8'h00, 3, 0);
    send_byte(8'h00);
    mon_on = 1'b0;
    cs_end();

    // R3 status user field
    cmd(8'h06);
    cs_begin(); send_byte(8'h01); send_byte(8'hF4); cs_end();
    rdsr_check(8'hF7, "R3 user field with busy and enable");
    wait_clks(WC + 100);
    rdsr_check(8'hF4, "R3 user field after cycle");

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule